// File: doc/BRIEF.md
# Floating-Point Operand Class Decoder

This block inspects one floating-point register value and reports which of ten categories it falls into. Each category has its own bit in a one-hot mask: signed infinities, signed normals, signed subnormals, signed zeros, and the two kinds of not-a-number (signaling and quiet). The mask is zero-extended onto an integer result bus, so that a write port of the integer register file can take it directly. It is used in the execute stage to implement a classify operation. Integer code then tests the mask with ordinary bit tests and branches on the result.

The operand input is 64 bits wide. A precision select chooses how the operand is read. In double precision the whole word is decoded. In single precision only the low 32 bits are decoded, and the upper half plays no part. The block is purely combinational. It never raises an exception flag, and this holds for signaling NaN inputs as well.

Top module: `fpc_classify`

## Requirements
- R1: Bits 9:0 of `class_o` always carry exactly one set bit, for every operand value and either precision.
- R2: Bits 31:10 of `class_o` are always zero.
- R3: The mask bit positions are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. A NaN selects bit 8 or bit 9 whatever its sign bit is.
- R4: With `dbl_i`=0, the operand is single precision. Bit 31 is the sign, bits 30:23 are the exponent and bits 22:0 are the fraction. Bits 63:32 have no effect on the result.
- R5: With `dbl_i`=1, the operand is double precision. Bit 63 is the sign, bits 62:52 are the exponent and bits 51:0 are the fraction.
- R6: An all-zero exponent with a zero fraction selects bit 3 if the sign is 1, or bit 4 if the sign is 0.
- R7: An all-zero exponent with a non-zero fraction selects bit 2 if the sign is 1, or bit 5 if the sign is 0.
- R8: An all-ones exponent with a zero fraction selects bit 0 if the sign is 1, or bit 7 if the sign is 0.
- R9: An all-ones exponent with a non-zero fraction is a NaN. It selects bit 9 when the top fraction bit is 1, and bit 8 when that bit is 0.
- R10: Any exponent that is neither all zeros nor all ones selects bit 1 if the sign is 1, or bit 6 if the sign is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 64 | Floating-point register value to classify |
| dbl_i | input | 1 | Precision select: 1 = double, 0 = single (low 32 bits) |
| class_o | output | 32 | One-hot class mask in bits 9:0, zero above |

## Verification
The block holds no state, so any defect in the field decode or in the class selection shows at the ports in the same evaluation as the operand that triggers it. A wrong exponent slice or a wrong sign tap moves the set bit to a neighbouring class, for example from normal to subnormal or from positive to negative. A wrong NaN test swaps bits 8 and 9. A precision mux that picks the wrong half makes the result depend on bits 63:32 in single mode. The bench drives the class boundaries of both formats, together with pseudo-random operands that are biased toward the extreme exponents. It compares every result against a behavioural model on the clock that follows each new operand.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   localparam int NUM_CLASS = 10;

   // Bit positions of the class mask.
   typedef enum logic [3:0] {
      CLS_NEG_INF  = 4'd0,
      CLS_NEG_NORM = 4'd1,
      CLS_NEG_SUB  = 4'd2,
      CLS_NEG_ZERO = 4'd3,
      CLS_POS_ZERO = 4'd4,
      CLS_POS_SUB  = 4'd5,
      CLS_POS_NORM = 4'd6,
      CLS_POS_INF  = 4'd7,
      CLS_SNAN     = 4'd8,
      CLS_QNAN     = 4'd9
   } fpc_class_e;

   // Reduced view of an operand: only what the class decision needs.
   typedef struct packed {
      logic sign;
      logic exp_zero;
      logic exp_ones;
      logic frac_zero;
      logic frac_top;
   } fpc_fields_t;

endpackage

// File: rtl/fpc_field_decode.sv
module fpc_field_decode
   import fpc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] val_i,
   output fpc_fields_t           flds_o
);

   localparam int TOT_W  = EXP_W + FRAC_W + 1;
   localparam int SIGN_B = TOT_W - 1;
   localparam int EXP_LO = FRAC_W;

   if (EXP_W < 2) begin : g_chk_exp
      $error("fpc_field_decode: EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_chk_frac
      $error("fpc_field_decode: FRAC_W must be at least 1");
   end

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = val_i[EXP_LO +: EXP_W];
   assign frac_f = val_i[FRAC_W-1:0];

   always_comb begin
      flds_o.sign      = val_i[SIGN_B];
      flds_o.exp_zero  = ~|exp_f;
      flds_o.exp_ones  = &exp_f;
      flds_o.frac_zero = ~|frac_f;
      flds_o.frac_top  = frac_f[FRAC_W-1];
   end

endmodule

// File: rtl/fpc_class_encode.sv
module fpc_class_encode
   import fpc_pkg::*;
#(
   parameter int MASK_W = NUM_CLASS
) (
   input  fpc_fields_t       flds_i,
   output logic [MASK_W-1:0] mask_o
);

   if (MASK_W != NUM_CLASS) begin : g_chk_mask
      $error("fpc_class_encode: MASK_W must equal the class count");
   end

   fpc_class_e sel;

   always_comb begin
      if (flds_i.exp_ones) begin
         if (flds_i.frac_zero)
            sel = flds_i.sign ? CLS_NEG_INF : CLS_POS_INF;
         else
            sel = flds_i.frac_top ? CLS_QNAN : CLS_SNAN;
      end else if (flds_i.exp_zero) begin
         if (flds_i.frac_zero)
            sel = flds_i.sign ? CLS_NEG_ZERO : CLS_POS_ZERO;
         else
            sel = flds_i.sign ? CLS_NEG_SUB : CLS_POS_SUB;
      end else begin
         sel = flds_i.sign ? CLS_NEG_NORM : CLS_POS_NORM;
      end
   end

   for (genvar gi = 0; gi < MASK_W; gi++) begin : g_bit
      assign mask_o[gi] = (sel == fpc_class_e'(gi));
   end

endmodule

// File: rtl/fpc_classify.sv
module fpc_classify
   import fpc_pkg::*;
#(
   parameter int OPND_W  = 64,
   parameter int RES_W   = 32,
   parameter int SP_EXP  = 8,
   parameter int SP_FRAC = 23,
   parameter int DP_EXP  = 11,
   parameter int DP_FRAC = 52,
   parameter bit DP_EN   = 1'b1
) (
   input  logic [OPND_W-1:0] opnd_i,
   input  logic              dbl_i,
   output logic [RES_W-1:0]  class_o
);

   localparam int SP_W  = SP_EXP + SP_FRAC + 1;
   localparam int DP_W  = DP_EXP + DP_FRAC + 1;
   localparam int PAD_W = RES_W - NUM_CLASS;

   if (RES_W <= NUM_CLASS) begin : g_chk_res
      $error("fpc_classify: RES_W too narrow for the class mask");
   end
   if (SP_W > OPND_W) begin : g_chk_sp
      $error("fpc_classify: single format wider than operand");
   end
   if (DP_EN && (DP_W != OPND_W)) begin : g_chk_dp
      $error("fpc_classify: double format must fill the operand");
   end

   fpc_fields_t             flds_sel;
   logic [NUM_CLASS-1:0]    mask;

   fpc_fields_t sp_flds;

   fpc_field_decode #(
      .EXP_W  (SP_EXP),
      .FRAC_W (SP_FRAC)
   ) u_sp_dec (
      .val_i  (opnd_i[SP_W-1:0]),
      .flds_o (sp_flds)
   );

   if (DP_EN) begin : g_dual
      fpc_fields_t dp_flds;

      fpc_field_decode #(
         .EXP_W  (DP_EXP),
         .FRAC_W (DP_FRAC)
      ) u_dp_dec (
         .val_i  (opnd_i[DP_W-1:0]),
         .flds_o (dp_flds)
      );

      assign flds_sel = dbl_i ? dp_flds : sp_flds;
   end else begin : g_single
      assign flds_sel = sp_flds;
   end

   fpc_class_encode #(
      .MASK_W (NUM_CLASS)
   ) u_enc (
      .flds_i (flds_sel),
      .mask_o (mask)
   );

   assign class_o = {{PAD_W{1'b0}}, mask};

endmodule

// File: rtl/fpc_classify_chk.sv
module fpc_classify_chk (
   input logic [63:0] opnd_i,
   input logic        dbl_i,
   input logic [31:0] class_o
);

   logic        s_sign;
   logic        s_eones;
   logic        s_fzero;
   logic        s_ftop;

   always_comb begin
      if (dbl_i) begin
         s_sign  = opnd_i[63];
         s_eones = &opnd_i[62:52];
         s_fzero = ~|opnd_i[51:0];
         s_ftop  = opnd_i[51];
      end else begin
         s_sign  = opnd_i[31];
         s_eones = &opnd_i[30:23];
         s_fzero = ~|opnd_i[22:0];
         s_ftop  = opnd_i[22];
      end
   end

   always_comb begin
      a_r1_onehot: assert ($countones(class_o[9:0]) == 1)
         else $error("class mask not one-hot");
      a_r2_upper_zero: assert (class_o[31:10] == 22'd0)
         else $error("upper result bits not zero");
      a_r3_sign_side: assert ((s_eones && !s_fzero) ||
                              (s_sign ? (class_o[7:4] == 4'd0) : (class_o[3:0] == 4'd0)))
         else $error("class lies on the wrong sign side");
      a_r8_inf_frac: assert (!(class_o[0] || class_o[7]) || (s_eones && s_fzero))
         else $error("infinity class without infinity encoding");
      a_r9_nan_kind: assert (!class_o[9] || (s_eones && s_ftop))
         else $error("quiet NaN class without quiet encoding");
      a_r9_snan_kind: assert (!class_o[8] || (s_eones && !s_fzero && !s_ftop))
         else $error("signaling NaN class without signaling encoding");
   end

endmodule

bind fpc_classify fpc_classify_chk u_chk (
   .opnd_i  (opnd_i),
   .dbl_i   (dbl_i),
   .class_o (class_o)
);

// File: tb/fpc_classify_bench.sv
`timescale 1ns/1ps
module fpc_classify_bench;

   logic        clk;
   logic        rst_n;
   logic [63:0] opnd;
   logic        dbl;
   logic [31:0] cls;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   fpc_classify u_fpc_classify (
      .opnd_i  (opnd),
      .dbl_i   (dbl),
      .class_o (cls)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // Behavioural model: returns the expected mask bit index.
   function automatic int ref_class(input logic [63:0] v, input logic d);
      int        e, emax;
      logic      s, qtop;
      logic [63:0] f;
      if (d) begin
         s = v[63]; e = int'(v[62:52]); f = {12'd0, v[51:0]};
         emax = 2047; qtop = v[51];
      end else begin
         s = v[31]; e = int'(v[30:23]); f = {41'd0, v[22:0]};
         emax = 255; qtop = v[22];
      end
      if (e == emax) begin
         if (f == 0) return s ? 0 : 7;
         return qtop ? 9 : 8;
      end
      if (e == 0) begin
         if (f == 0) return s ? 3 : 4;
         return s ? 2 : 5;
      end
      return s ? 1 : 6;
   endfunction

   task automatic check(input logic [63:0] v, input logic d, input string req);
      logic [31:0] exp_m;
      @(negedge clk);
      opnd = v;
      dbl  = d;
      @(posedge clk);
      #2;
      exp_m = 32'd1 << ref_class(v, d);
      n_run++;
      if (cls !== exp_m) begin
         n_fail++;
         $display("FAIL %s opnd=%h dbl=%0b actual=%h expected=%h", req, v, d, cls, exp_m);
      end
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] lfsr;
      rst_n = 1'b0;
      opnd  = 64'd0;
      dbl   = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Reset-time state: zero operand reads as positive zero (R6)
      check(64'h0, 1'b0, "R6 reset +0");

      // Single precision corners
      check(64'h0000_0000_8000_0000, 1'b0, "R6 sp -0");
      check(64'h0000_0000_3f80_0000, 1'b0, "R10 sp +norm");
      check(64'h0000_0000_bf80_0000, 1'b0, "R10 sp -norm");
      check(64'h0000_0000_7f7f_ffff, 1'b0, "R10 sp max norm");
      check(64'h0000_0000_0080_0000, 1'b0, "R10 sp min norm");
      check(64'h0000_0000_0000_0001, 1'b0, "R7 sp +sub");
      check(64'h0000_0000_8040_0000, 1'b0, "R7 sp -sub");
      check(64'h0000_0000_7f80_0000, 1'b0, "R8 sp +inf");
      check(64'h0000_0000_ff80_0000, 1'b0, "R8 sp -inf");
      check(64'h0000_0000_7fc0_0000, 1'b0, "R9 sp qnan");
      check(64'h0000_0000_ffc0_0001, 1'b0, "R9 R3 sp neg qnan");
      check(64'h0000_0000_7f80_0001, 1'b0, "R9 sp snan");
      check(64'h0000_0000_ffa0_0000, 1'b0, "R9 sp neg snan");
      // High half must be ignored in single mode
      check(64'hffff_ffff_0000_0000, 1'b0, "R4 sp high ignored +0");
      check(64'h7ff8_0000_3f80_0000, 1'b0, "R4 sp high ignored norm");
      check(64'hfff0_0000_7f80_0000, 1'b0, "R4 sp high ignored inf");

      // Double precision corners
      check(64'h3ff0_0000_0000_0000, 1'b1, "R5 R10 dp +norm");
      check(64'hbff0_0000_0000_0000, 1'b1, "R5 R10 dp -norm");
      check(64'h0010_0000_0000_0000, 1'b1, "R10 dp min norm");
      check(64'h7fef_ffff_ffff_ffff, 1'b1, "R10 dp max norm");
      check(64'h0000_0000_0000_0001, 1'b1, "R7 dp +sub");
      check(64'h800f_ffff_ffff_ffff, 1'b1, "R7 dp -sub");
      check(64'h8000_0000_0000_0000, 1'b1, "R6 dp -0");
      check(64'h0000_0000_0000_0000, 1'b1, "R6 dp +0");
      check(64'h7ff0_0000_0000_0000, 1'b1, "R8 dp +inf");
      check(64'hfff0_0000_0000_0000, 1'b1, "R8 dp -inf");
      check(64'h7ff8_0000_0000_0000, 1'b1, "R9 dp qnan");
      check(64'h7ff0_0000_0000_0001, 1'b1, "R9 dp snan");
      check(64'hfff4_0000_0000_0000, 1'b1, "R9 R3 dp neg snan");
      check(64'h0000_0000_7f80_0000, 1'b1, "R5 dp low word inf pattern");

      // Pseudo-random operands, exponent biased to the extremes (R1 R2)
      lfsr = 64'hace1_2468_1357_9bdf;
      for (int i = 0; i < 600; i++) begin
         logic [63:0] v;
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         v = lfsr;
         case (i % 5)
            0: begin v[62:52] = '1; v[30:23] = '1; end
            1: begin v[62:52] = '0; v[30:23] = '0; end
            2: begin v[51:0] = '0; v[22:0] = '0; end
            default: ;
         endcase
         check(v, i[0], "R1 R2 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule